// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block takes a configuration bitstream as a byte stream over a valid/ready interface and loads it into a target FPGA through that device's 8-bit parallel slave configuration port. Once `start` arrives, it hunts through the stream for a run of four consecutive 0xFF bytes. Bytes before that run are consumed and discarded. When the run is found, the block resets the target and walks it through the entry handshake. It then pushes the four 0xFF bytes and every byte after them into the target. Each byte is bit-reversed and clocked in with one generated CCLK pulse.

The host marks the final byte with `in_last`. After that byte is clocked in, the block releases the port in a fixed order, waits for the DONE pin to pass through the synchronizer, and reports one of five outcomes: pass, configuration failure, sync error or init timeout, or none while a session runs. The result and the count of bytes sent stay on the outputs until the next `start`.

The controller is a single state machine with these states: `ST_IDLE`, `ST_HUNT`, `ST_DESEL`, `ST_PROG`, `ST_INITW`, `ST_WRON`, `ST_SEL`, `ST_FETCH`, `ST_CLK_A`, `ST_CLK_H`, `ST_CLK_B`, `ST_REL_CS`, `ST_REL_WR`, `ST_SAMPLE` and `ST_FINISH`. Its transitions are:
- idle or finish to hunt, on start
- hunt to deselect, on the fourth 0xFF
- hunt to finish, on window overflow or an early last byte
- deselect to program, then program to init-wait, each after a timed wait
- init-wait to write-on, on INIT high
- init-wait to finish, on timeout
- write-on to select to fetch
- fetch to the three clock phases
- the last clock phase back to fetch, or to release-select when the byte was the last one
- release-select to release-write to sample to finish

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, the outputs are `cfg_prog`=1, `cfg_cs_n`=1, `cfg_wr`=0, `cfg_cclk`=0, `in_ready`=0, `status_valid`=0 and `byte_count`=0.
- R2: The sync run must be four consecutive 0xFF bytes, and any other byte restarts the run. If the run does not end within the first `SYNC_WIN` (256) bytes, the session ends with status 3 (sync error) and `cfg_cs_n` never goes low. A run that ends exactly on byte 256 is accepted.
- R3: The four sync bytes are sent to the target, followed by every later byte in order. `byte_count` equals the number of bytes strobed into the target.
- R4: Each byte is bit-reversed on `cfg_data`, so input bit i drives `cfg_data[7-i]`.
- R5: The entry sequence is, in order:
  - `cfg_prog` low with `cfg_cs_n` high, held for at least ceil(`MIN_WAIT_NS`/`CLK_NS`) cycles;
  - `cfg_prog` high for at least as long again;
  - a wait for synchronized `cfg_init` high;
  - `cfg_wr` high;
  - `cfg_cs_n` low in a later cycle.
- R6: If `cfg_init` stays low for `INIT_TIMEOUT` cycles, the session ends with status 4 (init error) and `cfg_cs_n` never goes low.
- R7: Each byte is strobed as CCLK low, then high for one cycle, then low. `cfg_data` is stable from the rising edge through the falling edge. `in_ready` is low while CCLK is high, and the select is active with write high during the pulse.
- R8: After the last byte, `cfg_cs_n` goes high first, and `cfg_wr` falls one cycle later. DONE is sampled after both have been released. Status is 1 (pass) if DONE is high, and 2 (configuration failure) if it is low.
- R9: `status_valid` and `status` hold, with `in_ready` low, until the next `start`. A new `start` runs a fresh session.
- R10: A stream whose last byte arrives before the sync run has completed ends with status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a session from idle or finish |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Block accepts the byte this cycle |
| cfg_prog | output | 1 | Target program line; low resets the target |
| cfg_cs_n | output | 1 | Target chip select, active low |
| cfg_wr | output | 1 | Target write enable, active high |
| cfg_cclk | output | 1 | Generated configuration clock |
| cfg_data | output | 8 | Bit-reversed configuration byte |
| cfg_init | input | 1 | Target INIT pin, asynchronous |
| cfg_done | input | 1 | Target DONE pin, asynchronous |
| status_valid | output | 1 | Session finished; status is meaningful |
| status | output | 3 | 0 none, 1 pass, 2 config fail, 3 sync error, 4 init error |
| byte_count | output | CNT_W | Bytes strobed into the target this session |

## Verification
A wrong hunt count shows at the ports as misplaced output. The first strobed byte is not 0xFF, extra leading bytes appear, or a stream that should abort raises the chip select. Each of these is visible at the first CCLK pulse after the sync decision. A wrong state in the entry or exit sequence shows as timing of `cfg_prog`, `cfg_wr` and `cfg_cs_n` edges that is short or out of order, within tens of cycles of the sync decision. A faulty datapath register shows as a mismatch between the byte read back from `cfg_data` at the CCLK rising edge and the byte the host sent, visible on that same pulse. A faulty counter shows in `byte_count` once `status_valid` rises.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DESEL,
        ST_PROG,
        ST_INITW,
        ST_WRON,
        ST_SEL,
        ST_FETCH,
        ST_CLK_A,
        ST_CLK_H,
        ST_CLK_B,
        ST_REL_CS,
        ST_REL_WR,
        ST_SAMPLE,
        ST_FINISH
    } ld_state_e;

    typedef enum logic [2:0] {
        RES_NONE     = 3'd0,
        RES_PASS     = 3'd1,
        RES_CFG_FAIL = 3'd2,
        RES_SYNC_ERR = 3'd3,
        RES_INIT_ERR = 3'd4
    } ld_result_e;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;

endpackage

// File: rtl/cfg_sync_hunter.sv
module cfg_sync_hunter #(
    parameter int          WIN  = 256,
    parameter int          RUN  = 4,
    parameter logic [7:0]  PATT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] byte_in,
    output logic       hit,
    output logic       win_over
);
    localparam int RW = $clog2(RUN + 1);
    localparam int CW = $clog2(WIN + 1);

    logic [RW-1:0] run_q;
    logic [CW-1:0] seen_q;
    logic          is_patt;

    assign is_patt  = (byte_in == PATT);
    assign hit      = take && is_patt && (run_q == RW'(RUN - 1));
    assign win_over = take && !hit && (seen_q == CW'(WIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            seen_q <= '0;
        end else if (clear) begin
            run_q  <= '0;
            seen_q <= '0;
        end else if (take) begin
            seen_q <= seen_q + CW'(1);
            if (hit || !is_patt) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + RW'(1);
            end
        end
    end

    // R2: the run counter never reaches the full run length while hunting
    assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RW'(RUN));

    // R2: the window count never exceeds the search window
    assert_window_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q <= CW'(WIN));

endmodule

// File: rtl/cfg_bit_rev.sv
module cfg_bit_rev #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_swap
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R5: without a load the timer only counts down by one
    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int MIN_WAIT_NS  = 300,
    parameter int INIT_TIMEOUT = 1000,
    parameter int SYNC_WIN     = 256,
    parameter int SYNC_RUN     = 4,
    parameter int PIN_SYNC     = 2,
    parameter int CNT_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             cfg_prog,
    output logic             cfg_cs_n,
    output logic             cfg_wr,
    output logic             cfg_cclk,
    output logic [7:0]       cfg_data,
    input  logic             cfg_init,
    input  logic             cfg_done,
    output logic             status_valid,
    output logic [2:0]       status,
    output logic [CNT_W-1:0] byte_count
);
    localparam int WAIT_RAW = (MIN_WAIT_NS + CLK_NS - 1) / CLK_NS;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int SETTLE   = PIN_SYNC + 1;
    localparam int TMAX_A   = (WAIT_CYC > INIT_TIMEOUT) ? WAIT_CYC : INIT_TIMEOUT;
    localparam int TMAX     = (TMAX_A > SETTLE) ? TMAX_A : SETTLE;
    localparam int TW       = $clog2(TMAX + 1);
    localparam int RPW      = $clog2(SYNC_RUN + 1);

    ld_state_e        state_q, state_d;
    ld_result_e       result_q, res_d;
    logic [7:0]       data_q, rev_in, rev_out;
    logic             last_q, sync_last_q;
    logic [RPW-1:0]   replay_q;
    logic [CNT_W-1:0] count_q;
    logic             init_s, done_s;
    logic             accept, start_ok, hunt_take, hunt_hit, hunt_over;
    logic             tmr_load, tmr_exp;
    logic [TW-1:0]    tmr_val;
    logic             take_replay, take_input, res_set;

    // ---------------- helpers ----------------
    cfg_pin_sync #(.STAGES(PIN_SYNC)) u_init_sync (
        .clk(clk), .rst_n(rst_n), .din(cfg_init), .dout(init_s));

    cfg_pin_sync #(.STAGES(PIN_SYNC)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .din(cfg_done), .dout(done_s));

    cfg_sync_hunter #(.WIN(SYNC_WIN), .RUN(SYNC_RUN), .PATT(SYNC_BYTE)) u_hunter (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .take(hunt_take),
        .byte_in(in_data), .hit(hunt_hit), .win_over(hunt_over));

    cfg_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp));

    assign rev_in = take_replay ? SYNC_BYTE : in_data;

    cfg_bit_rev #(.W(8)) u_rev (.din(rev_in), .dout(rev_out));

    assign accept    = in_valid && in_ready;
    assign start_ok  = start && (state_q == ST_IDLE || state_q == ST_FINISH);
    assign hunt_take = (state_q == ST_HUNT) && accept;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d     = state_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        take_replay = 1'b0;
        take_input  = 1'b0;
        res_set     = 1'b0;
        res_d       = RES_NONE;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start) state_d = ST_HUNT;
            end
            ST_HUNT: begin
                if (hunt_hit) begin
                    state_d  = ST_DESEL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WAIT_CYC - 1);
                end else if (hunt_over || (hunt_take && in_last)) begin
                    state_d = ST_FINISH;
                    res_set = 1'b1;
                    res_d   = RES_SYNC_ERR;
                end
            end
            ST_DESEL: begin
                if (tmr_exp) begin
                    state_d  = ST_PROG;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WAIT_CYC - 1);
                end
            end
            ST_PROG: begin
                if (tmr_exp) begin
                    state_d  = ST_INITW;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(INIT_TIMEOUT - 1);
                end
            end
            ST_INITW: begin
                if (init_s) begin
                    state_d = ST_WRON;
                end else if (tmr_exp) begin
                    state_d = ST_FINISH;
                    res_set = 1'b1;
                    res_d   = RES_INIT_ERR;
                end
            end
            ST_WRON:  state_d = ST_SEL;
            ST_SEL:   state_d = ST_FETCH;
            ST_FETCH: begin
                if (replay_q != '0) begin
                    take_replay = 1'b1;
                    state_d     = ST_CLK_A;
                end else if (accept) begin
                    take_input = 1'b1;
                    state_d    = ST_CLK_A;
                end
            end
            ST_CLK_A: state_d = ST_CLK_H;
            ST_CLK_H: state_d = ST_CLK_B;
            ST_CLK_B: state_d = last_q ? ST_REL_CS : ST_FETCH;
            ST_REL_CS: state_d = ST_REL_WR;
            ST_REL_WR: begin
                state_d  = ST_SAMPLE;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE - 1);
            end
            ST_SAMPLE: begin
                if (tmr_exp) begin
                    state_d = ST_FINISH;
                    res_set = 1'b1;
                    res_d   = done_s ? RES_PASS : RES_CFG_FAIL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q      <= '0;
            last_q      <= 1'b0;
            sync_last_q <= 1'b0;
            replay_q    <= '0;
            count_q     <= '0;
            result_q    <= RES_NONE;
        end else begin
            if (start_ok) begin
                count_q     <= '0;
                result_q    <= RES_NONE;
                replay_q    <= '0;
                sync_last_q <= 1'b0;
                last_q      <= 1'b0;
            end
            if (hunt_hit) begin
                replay_q    <= RPW'(SYNC_RUN);
                sync_last_q <= in_last;
            end
            if (take_replay) begin
                data_q   <= rev_out;
                replay_q <= replay_q - RPW'(1);
                last_q   <= (replay_q == RPW'(1)) && sync_last_q;
            end
            if (take_input) begin
                data_q <= rev_out;
                last_q <= in_last;
            end
            if (take_replay || take_input) begin
                count_q <= count_q + CNT_W'(1);
            end
            if (res_set) begin
                result_q <= res_d;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cfg_prog     = 1'b1;
        cfg_cs_n     = 1'b1;
        cfg_wr       = 1'b0;
        cfg_cclk     = 1'b0;
        in_ready     = 1'b0;
        status_valid = 1'b0;
        unique case (state_q)
            ST_HUNT:   in_ready = 1'b1;
            ST_DESEL:  cfg_prog = 1'b0;
            ST_WRON:   cfg_wr = 1'b1;
            ST_SEL, ST_CLK_A, ST_CLK_B: begin
                cfg_wr   = 1'b1;
                cfg_cs_n = 1'b0;
            end
            ST_FETCH: begin
                cfg_wr   = 1'b1;
                cfg_cs_n = 1'b0;
                in_ready = (replay_q == '0);
            end
            ST_CLK_H: begin
                cfg_wr   = 1'b1;
                cfg_cs_n = 1'b0;
                cfg_cclk = 1'b1;
            end
            ST_REL_CS: cfg_wr = 1'b1;
            ST_FINISH: status_valid = 1'b1;
            default: ;
        endcase
    end

    assign cfg_data   = data_q;
    assign status     = result_q;
    assign byte_count = count_q;

    // ---------------- assertions ----------------
    // R5: select only while write is held
    assert_select_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cs_n |-> cfg_wr);

    // R5: write rises only after program is released and INIT was seen
    assert_write_after_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr) |-> (cfg_prog && init_s));

    // R7: CCLK high only inside a selected transfer, with input stalled
    assert_cclk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cclk |-> (!cfg_cs_n && !in_ready));

    // R7: data held across the whole pulse
    assert_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cclk || $fell(cfg_cclk)) |-> $stable(cfg_data));

    // R8: write drops only after select was already released
    assert_release_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_wr) |-> (cfg_cs_n && $past(cfg_cs_n)));

    // R3: byte count moves by at most one, or clears
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count == $past(byte_count)) ||
        (byte_count == $past(byte_count) + CNT_W'(1)) ||
        (byte_count == '0));

    // R9: a finished result holds until start
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && !start) |=> (status_valid && $stable(status)));

endmodule

// File: tb/test_fpga_cfg_loader.sv
module test_fpga_cfg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_NS    = 300;
    localparam int INIT_TO    = 100;
    localparam int WIN        = 256;
    localparam int EXP_WAIT   = WAIT_NS / CLK_PERIOD;

    logic        clk, rst_n, start, in_valid, in_last, in_ready;
    logic [7:0]  in_data, cfg_data;
    logic        cfg_prog, cfg_cs_n, cfg_wr, cfg_cclk, cfg_init, cfg_done, status_valid;
    logic [2:0]  status;
    logic [31:0] byte_count;

    fpga_cfg_loader #(
        .CLK_NS(CLK_PERIOD), .MIN_WAIT_NS(WAIT_NS), .INIT_TIMEOUT(INIT_TO),
        .SYNC_WIN(WIN), .SYNC_RUN(4), .PIN_SYNC(2), .CNT_W(32)
    ) i_fpga_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .cfg_prog(cfg_prog), .cfg_cs_n(cfg_cs_n),
        .cfg_wr(cfg_wr), .cfg_cclk(cfg_cclk), .cfg_data(cfg_data), .cfg_init(cfg_init),
        .cfg_done(cfg_done), .status_valid(status_valid), .status(status),
        .byte_count(byte_count));

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[j] = v[7-j];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Port monitor and target model, evaluated between edges
    logic [7:0] got[$];
    logic [7:0] raw[$];
    int  t_pf, t_pr, t_wr, t_wf, t_csf, t_csr, proto_bad, init_cnt;
    bit  init_at_wr, cs_low_seen, tgt_good, tgt_init_ok;
    logic p_cclk, p_cs, p_wr, p_prog;
    logic [7:0] d_rise;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_cclk = 1'b0; p_cs = 1'b1; p_wr = 1'b0; p_prog = 1'b1;
            cfg_init = 1'b0; cfg_done = 1'b0; init_cnt = 0;
        end else begin
            if (!p_cclk && cfg_cclk) begin
                d_rise = cfg_data;
                raw.push_back(cfg_data);
                got.push_back(rev8(cfg_data));
                if (cfg_cs_n || !cfg_wr || in_ready) proto_bad++;
            end
            if (p_cclk && !cfg_cclk && cfg_data != d_rise) proto_bad++;
            if (p_cclk && cfg_cclk) proto_bad++;
            if (!cfg_cs_n && !cfg_wr) proto_bad++;
            if (p_prog && !cfg_prog) t_pf = cyc;
            if (!p_prog && cfg_prog) t_pr = cyc;
            if (!p_wr && cfg_wr) begin t_wr = cyc; init_at_wr = cfg_init; end
            if (p_wr && !cfg_wr) t_wf = cyc;
            if (p_cs && !cfg_cs_n) begin t_csf = cyc; cs_low_seen = 1'b1; end
            if (!p_cs && cfg_cs_n) t_csr = cyc;
            if (!cfg_prog) begin
                init_cnt = 0; cfg_init = 1'b0; cfg_done = 1'b0;
            end else if (tgt_init_ok) begin
                if (init_cnt < 5) init_cnt++;
                else cfg_init = 1'b1;
            end
            if (p_wr && !cfg_wr && tgt_good) cfg_done = 1'b1;
            p_cclk = cfg_cclk; p_cs = cfg_cs_n; p_wr = cfg_wr; p_prog = cfg_prog;
        end
    end

    task automatic session(input string name, input logic [7:0] s[$], input bit init_ok, input bit good);
        int k, run, g, mis, exp_st;
        logic [7:0] expq[$];
        string rq;
        k = -1; run = 0;
        for (int i = 0; i < s.size() && i < WIN; i++) begin
            run = (s[i] == 8'hFF) ? run + 1 : 0;
            if (run == 4) begin k = i - 3; break; end
        end
        if (k >= 0 && init_ok) expq = s[k:$];
        exp_st = (k < 0) ? 3 : (!init_ok ? 4 : (good ? 1 : 2));
        rq = (k < 0) ? ((s.size() >= WIN) ? "R2" : "R10") : (!init_ok ? "R6" : "R8");

        got.delete(); raw.delete();
        t_pf = -1; t_pr = -1; t_wr = -1; t_wf = -1; t_csf = -1; t_csr = -1;
        proto_bad = 0; cs_low_seen = 1'b0; init_at_wr = 1'b0;
        tgt_good = good; tgt_init_ok = init_ok;

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < s.size(); i++) begin
            in_valid = 1'b1; in_data = s[i]; in_last = (i == s.size() - 1);
            g = 0;
            while (!in_ready && !status_valid && g < 5000) begin @(negedge clk); g++; end
            if (!in_ready) break;
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        g = 0;
        while (!status_valid && g < 20000) begin @(negedge clk); g++; end
        chk(status_valid, "R9", {name, " session finished"}, status_valid, 1);
        chk(status == exp_st, rq, {name, " status"}, status, exp_st);

        mis = 0;
        foreach (expq[i]) if (i < got.size() && got[i] != expq[i]) mis++;
        chk(got.size() == expq.size(), "R3", {name, " bytes strobed"}, got.size(), expq.size());
        chk(mis == 0, "R3", {name, " byte mismatches"}, mis, 0);
        chk(byte_count == expq.size(), "R3", {name, " byte_count"}, byte_count, expq.size());
        chk(proto_bad == 0, "R7", {name, " strobe protocol violations"}, proto_bad, 0);
        if (expq.size() > 4)
            chk(raw[4] == rev8(expq[4]), "R4", {name, " reversed pins"}, raw[4], rev8(expq[4]));

        if (k >= 0 && init_ok) begin
            chk(t_pr - t_pf >= EXP_WAIT, "R5", {name, " program low cycles"}, t_pr - t_pf, EXP_WAIT);
            chk(t_wr - t_pr >= EXP_WAIT, "R5", {name, " program-to-write cycles"}, t_wr - t_pr, EXP_WAIT);
            chk(init_at_wr, "R5", {name, " INIT high at write"}, init_at_wr, 1);
            chk(t_csf > t_wr, "R5", {name, " select after write"}, t_csf, t_wr + 1);
            chk(t_csr >= 0 && t_wf == t_csr + 1, "R8", {name, " write falls after select"}, t_wf, t_csr + 1);
        end else begin
            chk(!cs_low_seen, rq, {name, " select never asserted"}, cs_low_seen, 0);
        end

        repeat (12) @(negedge clk);
        chk(status_valid && status == exp_st && !in_ready, "R9", {name, " result held"}, status, exp_st);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] sa[$], sc[$], sd[$], se[$], sg[$];
        rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        tgt_good = 1'b0; tgt_init_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_prog == 1'b1, "R1", "prog after reset", cfg_prog, 1);
        chk(cfg_cs_n == 1'b1 && cfg_wr == 1'b0 && cfg_cclk == 1'b0, "R1", "port idle",
            {cfg_cs_n, cfg_wr, cfg_cclk}, 3'b100);
        chk(!in_ready && !status_valid && byte_count == 0, "R1", "ready/status/count",
            {in_ready, status_valid}, 0);

        sa = '{8'h12, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
               8'h01, 8'hA5, 8'h3C, 8'h80, 8'h7E, 8'h55};
        session("pass", sa, 1'b1, 1'b1);
        session("done-low", sa, 1'b1, 1'b0);

        for (int i = 0; i < 64; i++) begin
            sc.push_back(8'hFF); sc.push_back(8'hFF); sc.push_back(8'hFF); sc.push_back(8'h00);
        end
        session("window", sc, 1'b1, 1'b1);

        for (int i = 0; i < 252; i++) sd.push_back(8'h00);
        for (int i = 0; i < 4; i++) sd.push_back(8'hFF);
        sd.push_back(8'h0F); sd.push_back(8'hF0); sd.push_back(8'hC3);
        session("edge256", sd, 1'b1, 1'b1);

        se = '{8'h01, 8'hFF, 8'hFF};
        session("early-end", se, 1'b1, 1'b1);

        session("no-init", sa, 1'b0, 1'b1);

        sg = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
        session("sync-only", sg, 1'b1, 1'b1);

        summary();
        $finish;
    end
endmodule